// File: doc/BRIEF.md
# UART Line and Modem Status Logic

This block holds the status registers a host reads from a 16550-style serial port: the line status byte and a reduced modem status byte. It collects receive error tags for each character, transmitter emptiness and the CTS line. It also raises the receiver line status interrupt request. The shift registers, FIFOs, baud generator and other registers stay outside the block and reach it as plain strobes and level signals.

Error and change bits are sticky and clear when the host reads them. An event that arrives in the same cycle as the read survives for the next read. In FIFO mode the block counts how many errored characters sit in the receive FIFO, so the FIFO error bit clears only when none are left. In single-character mode that bit always reads as zero.

Top module: `uart_status_regs`

## Requirements
- R1: While reset is applied and just after it, `lsrValue` reads 8'h60 (bits 5 and 6 high, the rest low) when the transmit empty inputs are high, `msrValue` reads 8'h00 and `lineIrq` is low.
- R2: A `rxOverrun` pulse sets line status bit 1. A `rxPush` with `rxParityErr`, `rxFrameErr` or `rxBreak` sets bit 2, 3 or 4 respectively. These bits stay set until a cycle with `lsrRd` high clears them. An error arriving in that same cycle is still set afterwards.
- R3: `lineIrq` is high exactly when `ieLineStatus` is high and any of line status bits 1 to 4 is set. It falls in the cycle after a read clears those bits.
- R4: A `thrWrite` clears line status bit 6 on the next cycle. The bit stays low, and a line status read does not set or clear it, until the transmit source and `tsrEmpty` are both high.
- R5: The transmit source for bits 5 and 6 is `txFifoEmpty` when `fifoMode` is high and `thrEmpty` otherwise. Bit 5 takes the source one cycle later and also drops after a `thrWrite`.
- R6: Line status bit 7 reads 0 whenever `fifoMode` is low.
- R7: In FIFO mode, bit 7 is set while the receive FIFO holds any character pushed with a parity, framing or break tag. Each such character leaves through `rxPop` with `rxPopErr` high. A line status read clears bit 7 only when no errored character remains.
- R8: Modem status bit 0 is set two clock edges after `ctsIn` is first sampled at a new level, and is cleared by `msrRd`. A change that is detected in the same cycle as the read sets the bit again.
- R9: Modem status bit 4 shows `ctsIn` after a two-stage synchronizer. Bits 1, 2, 3, 5, 6 and 7 always read 0.
- R10: Line status bit 0 follows `rxDataReady` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | FIFO mode enable |
| ieLineStatus | input | 1 | Receiver line status interrupt enable |
| rxDataReady | input | 1 | Receive data available |
| rxPush | input | 1 | A character enters the receive path |
| rxOverrun | input | 1 | Overrun event pulse |
| rxParityErr | input | 1 | Parity error tag of the pushed character |
| rxFrameErr | input | 1 | Framing error tag of the pushed character |
| rxBreak | input | 1 | Break tag of the pushed character |
| rxPop | input | 1 | Host reads a character from the receive FIFO |
| rxPopErr | input | 1 | The popped character carries an error tag |
| thrWrite | input | 1 | Host writes a transmit character |
| thrEmpty | input | 1 | Transmit holding register empty |
| txFifoEmpty | input | 1 | Transmit FIFO empty |
| tsrEmpty | input | 1 | Transmit shift register empty |
| ctsIn | input | 1 | Asynchronous CTS line |
| lsrRd | input | 1 | Host read strobe for the line status byte |
| msrRd | input | 1 | Host read strobe for the modem status byte |
| lsrValue | output | 8 | Line status read value |
| msrValue | output | 8 | Modem status read value |
| lineIrq | output | 1 | Receiver line status interrupt request |

## Verification
On every cycle the assertions check these properties:
- a pushed parity error is set on the next cycle;
- the interrupt falls after a clean read;
- a transmit write clears bit 6;
- bit 7 stays low outside FIFO mode, and holds in FIFO mode until a read;
- a synchronized CTS edge sets the change flag;
- the unsupported modem bits stay at zero.

Only the bench scenarios show the rest. These are the full sweep of error tag combinations against the interrupt enable, and an error that arrives in the same cycle as a read. They also include the FIFO error counter holding bit 7 across reads until the last errored character is popped, and a CTS change that coincides with a modem status read.

// File: rtl/uart_status_pkg.sv
package uart_status_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic       lsrClr;    // host read of the line status byte
    logic       msrClr;    // host read of the modem status byte
    logic       ctsToggle; // synchronized CTS changed level
    logic [3:0] errSet;    // {break, framing, parity, overrun}
    logic       txLoad;    // transmit character written
    logic       errPush;   // errored character entered receive FIFO
    logic       errPop;    // errored character left receive FIFO
  } statusStrobes_t;

endpackage

// File: rtl/uart_status_ctrl.sv
module uart_status_ctrl
  import uart_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ctsIn,
  input  logic           lsrRd,
  input  logic           msrRd,
  input  logic           rxPush,
  input  logic           rxOverrun,
  input  logic           rxParityErr,
  input  logic           rxFrameErr,
  input  logic           rxBreak,
  input  logic           rxPop,
  input  logic           rxPopErr,
  input  logic           thrWrite,
  output statusStrobes_t strobes,
  output logic           ctsLevel
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] ctsChain;
  logic          ctsPrev;

  // Synchronizer chain; the stage count is a parameter.
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) ctsChain <= '0;
        else       ctsChain <= ctsIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) ctsChain <= '0;
        else       ctsChain <= {ctsChain[LAST-1:0], ctsIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) ctsPrev <= 1'b0;
    else       ctsPrev <= ctsChain[LAST];
  end

  assign ctsLevel = ctsChain[LAST];

  logic rxTagged;
  assign rxTagged = rxParityErr | rxFrameErr | rxBreak;

  always_comb begin
    strobes.lsrClr    = lsrRd;
    strobes.msrClr    = msrRd;
    strobes.ctsToggle = ctsChain[LAST] ^ ctsPrev;
    strobes.errSet    = {rxPush & rxBreak, rxPush & rxFrameErr,
                         rxPush & rxParityErr, rxOverrun};
    strobes.txLoad    = thrWrite;
    strobes.errPush   = rxPush & rxTagged;
    strobes.errPop    = rxPop & rxPopErr;
  end

endmodule

// File: rtl/uart_status_datapath.sv
module uart_status_datapath
  import uart_status_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  statusStrobes_t strobes,
  input  logic           fifoMode,
  input  logic           rxDataReady,
  input  logic           thrEmpty,
  input  logic           txFifoEmpty,
  input  logic           tsrEmpty,
  input  logic           ctsLevel,
  output logic [7:0]     lsrValue,
  output logic [7:0]     msrValue
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FIFO_DEPTH);

  logic [3:0]       errBits;
  logic             threBit;
  logic             temtBit;
  logic             fifoErrBit;
  logic             ctsDelta;
  logic [CNT_W-1:0] errCount;
  logic [CNT_W-1:0] errCountNext;
  logic             txSource;

  assign txSource = fifoMode ? txFifoEmpty : thrEmpty;

  // Sticky error bits: a new error wins over a read-clear.
  always_ff @(posedge clk) begin
    if (!rstN) errBits <= '0;
    else       errBits <= strobes.errSet | (errBits & {4{~strobes.lsrClr}});
  end

  // Count of errored characters held in the receive FIFO.
  always_comb begin
    errCountNext = errCount;
    if (!fifoMode) begin
      errCountNext = '0;
    end else if (strobes.errPush && !strobes.errPop) begin
      if (errCount != CNT_MAX) errCountNext = errCount + 1'b1;
    end else if (strobes.errPop && !strobes.errPush) begin
      if (errCount != '0) errCountNext = errCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errCount <= '0;
    else       errCount <= errCountNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     fifoErrBit <= 1'b0;
    else if (!fifoMode)            fifoErrBit <= 1'b0;
    else if (errCountNext != '0)   fifoErrBit <= 1'b1;
    else if (strobes.lsrClr)       fifoErrBit <= 1'b0;
  end

  // Transmit emptiness.
  always_ff @(posedge clk) begin
    if (!rstN) threBit <= 1'b1;
    else       threBit <= txSource & ~strobes.txLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      temtBit <= 1'b1;
    else if (strobes.txLoad)        temtBit <= 1'b0;
    else if (txSource && tsrEmpty)  temtBit <= 1'b1;
  end

  // CTS change flag: a fresh toggle wins over a read-clear.
  always_ff @(posedge clk) begin
    if (!rstN) ctsDelta <= 1'b0;
    else       ctsDelta <= strobes.ctsToggle | (ctsDelta & ~strobes.msrClr);
  end

  assign lsrValue = {fifoErrBit & fifoMode, temtBit, threBit, errBits, rxDataReady};
  assign msrValue = {3'b000, ctsLevel, 3'b000, ctsDelta};

endmodule

// File: rtl/uart_status_regs.sv
module uart_status_regs
  import uart_status_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoMode,
  input  logic       ieLineStatus,
  input  logic       rxDataReady,
  input  logic       rxPush,
  input  logic       rxOverrun,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rxBreak,
  input  logic       rxPop,
  input  logic       rxPopErr,
  input  logic       thrWrite,
  input  logic       thrEmpty,
  input  logic       txFifoEmpty,
  input  logic       tsrEmpty,
  input  logic       ctsIn,
  input  logic       lsrRd,
  input  logic       msrRd,
  output logic [7:0] lsrValue,
  output logic [7:0] msrValue,
  output logic       lineIrq
);

  statusStrobes_t strobes;
  logic           ctsLevel;

  uart_status_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctsIn(ctsIn), .lsrRd(lsrRd), .msrRd(msrRd),
    .rxPush(rxPush), .rxOverrun(rxOverrun), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak), .rxPop(rxPop),
    .rxPopErr(rxPopErr), .thrWrite(thrWrite), .strobes(strobes),
    .ctsLevel(ctsLevel)
  );

  uart_status_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fifoMode(fifoMode),
    .rxDataReady(rxDataReady), .thrEmpty(thrEmpty), .txFifoEmpty(txFifoEmpty),
    .tsrEmpty(tsrEmpty), .ctsLevel(ctsLevel), .lsrValue(lsrValue),
    .msrValue(msrValue)
  );

  assign lineIrq = ieLineStatus & (|lsrValue[4:1]);

endmodule

// File: rtl/uart_status_check.sv
module uart_status_check (
  input logic       clk,
  input logic       rstN,
  input logic       fifoMode,
  input logic       rxPush,
  input logic       rxOverrun,
  input logic       rxParityErr,
  input logic       thrWrite,
  input logic       lsrRd,
  input logic [7:0] lsrValue,
  input logic [7:0] msrValue,
  input logic       lineIrq
);

  a_r2_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxParityErr) |=> lsrValue[2]);

  a_r3_irq_drop: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRd && !rxPush && !rxOverrun) |=> !lineIrq);

  a_r4_temt_load: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !lsrValue[6]);

  a_r6_fifo_err_off: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |-> !lsrValue[7]);

  a_r7_fifo_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && lsrValue[7] && !lsrRd) |=> (lsrValue[7] || !fifoMode));

  a_r8_cts_flag: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(msrValue[4]) |=> msrValue[0]);

  a_r9_msr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (msrValue[3:1] == 3'b000) && (msrValue[7:5] == 3'b000));

endmodule

bind uart_status_regs uart_status_check i_chk (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .rxPush(rxPush),
  .rxOverrun(rxOverrun), .rxParityErr(rxParityErr), .thrWrite(thrWrite),
  .lsrRd(lsrRd), .lsrValue(lsrValue), .msrValue(msrValue), .lineIrq(lineIrq)
);

// File: tb/test_uart_status_regs.sv
`timescale 1ns/1ps
module test_uart_status_regs;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoMode = 0, ieLineStatus = 0, rxDataReady = 0;
  logic rxPush = 0, rxOverrun = 0, rxParityErr = 0, rxFrameErr = 0, rxBreak = 0;
  logic rxPop = 0, rxPopErr = 0, thrWrite = 0;
  logic thrEmpty = 1, txFifoEmpty = 1, tsrEmpty = 1;
  logic ctsIn = 0, lsrRd = 0, msrRd = 0;
  logic [7:0] lsrValue, msrValue;
  logic lineIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_status_regs i_uart_status_regs (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .ieLineStatus(ieLineStatus),
    .rxDataReady(rxDataReady), .rxPush(rxPush), .rxOverrun(rxOverrun),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .rxPop(rxPop), .rxPopErr(rxPopErr), .thrWrite(thrWrite),
    .thrEmpty(thrEmpty), .txFifoEmpty(txFifoEmpty), .tsrEmpty(tsrEmpty),
    .ctsIn(ctsIn), .lsrRd(lsrRd), .msrRd(msrRd), .lsrValue(lsrValue),
    .msrValue(msrValue), .lineIrq(lineIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance one clock edge; inputs are driven and outputs sampled 1 ns after it.
  task automatic cycle(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cycle(3);
    check("R1 lsr reset", lsrValue, 8'h60);
    check("R1 msr reset", msrValue, 8'h00);
    check("R1 irq reset", lineIrq, 0);
    rstN = 1'b1;
    cycle();
    check("R1 lsr after reset", lsrValue, 8'h60);

    // R10: bit 0 mirrors data ready combinationally
    rxDataReady = 1; #1;
    check("R10 data ready", lsrValue[0], 1);
    rxDataReady = 0; #1;
    check("R10 data ready low", lsrValue[0], 0);

    // R2 / R3 sweep over all error tag combinations
    for (int m = 0; m < 16; m++) begin
      logic ie;
      ie = (m % 3) != 0;
      ieLineStatus = ie;
      rxOverrun = m[0]; rxParityErr = m[1]; rxFrameErr = m[2]; rxBreak = m[3];
      rxPush = 1;
      cycle();
      rxPush = 0; rxOverrun = 0; rxParityErr = 0; rxFrameErr = 0; rxBreak = 0;
      cycle();
      check("R2 error bits set", lsrValue[4:1], m);
      check("R3 irq level", lineIrq, (ie && m != 0) ? 1 : 0);
      check("R6 fifo error off", lsrValue[7], 0);
      lsrRd = 1; #1;
      check("R2 read value", lsrValue[4:1], m);
      cycle();
      lsrRd = 0;
      check("R2 cleared by read", lsrValue[4:1], 0);
      check("R3 irq dropped", lineIrq, 0);
    end

    // R2: error in the same cycle as the read survives
    ieLineStatus = 1;
    rxOverrun = 1; cycle(); rxOverrun = 0;
    lsrRd = 1; rxPush = 1; rxFrameErr = 1;
    cycle();
    lsrRd = 0; rxPush = 0; rxFrameErr = 0;
    check("R2 same-cycle error kept", lsrValue[4:1], 4'b0100);
    check("R3 irq kept", lineIrq, 1);
    lsrRd = 1; cycle(); lsrRd = 0;

    // R4 / R5 transmit emptiness, single-character mode
    thrWrite = 1; thrEmpty = 0; tsrEmpty = 0;
    cycle();
    thrWrite = 0;
    check("R4 temt cleared", lsrValue[6], 0);
    check("R5 thre cleared", lsrValue[5], 0);
    lsrRd = 1; cycle(); lsrRd = 0;
    check("R4 read leaves temt", lsrValue[6], 0);
    tsrEmpty = 1; cycle();
    check("R4 temt waits for holding", lsrValue[6], 0);
    thrEmpty = 1; cycle();
    check("R4 temt set", lsrValue[6], 1);
    check("R5 thre set", lsrValue[5], 1);

    // R5 FIFO mode uses the transmit FIFO flag
    fifoMode = 1; txFifoEmpty = 0;
    thrWrite = 1; cycle(); thrWrite = 0;
    cycle();
    check("R5 temt fifo low", lsrValue[6], 0);
    check("R5 thre fifo low", lsrValue[5], 0);
    txFifoEmpty = 1; cycle();
    check("R5 temt fifo set", lsrValue[6], 1);
    check("R5 thre fifo set", lsrValue[5], 1);

    // R7 FIFO error counting
    rxPush = 1; rxParityErr = 1; cycle(2);
    rxPush = 0; rxParityErr = 0;
    check("R7 fifo error set", lsrValue[7], 1);
    rxPop = 1; rxPopErr = 1; cycle(); rxPop = 0; rxPopErr = 0;
    lsrRd = 1; cycle(); lsrRd = 0;
    check("R7 kept with one left", lsrValue[7], 1);
    rxPop = 1; rxPopErr = 1; cycle(); rxPop = 0; rxPopErr = 0;
    check("R7 sticky until read", lsrValue[7], 1);
    lsrRd = 1; cycle(); lsrRd = 0;
    check("R7 cleared when none left", lsrValue[7], 0);
    rxPush = 1; rxBreak = 1; cycle(); rxPush = 0; rxBreak = 0;
    check("R7 break sets", lsrValue[7], 1);
    fifoMode = 0; #1;
    check("R6 off forces zero", lsrValue[7], 0);
    cycle();
    check("R6 off stays zero", lsrValue[7], 0);
    lsrRd = 1; cycle(); lsrRd = 0;

    // R8 / R9 CTS change flag
    ctsIn = 1;
    cycle();
    check("R9 cts after one edge", msrValue[4], 0);
    check("R8 flag after one edge", msrValue[0], 0);
    cycle();
    check("R9 cts synced", msrValue[4], 1);
    check("R8 flag not yet", msrValue[0], 0);
    cycle();
    check("R8 flag set", msrValue[0], 1);
    check("R9 unused bits", msrValue & 8'hEE, 0);
    msrRd = 1; cycle(); msrRd = 0;
    check("R8 flag cleared", msrValue[0], 0);
    ctsIn = 0;
    cycle(2);
    check("R9 cts low synced", msrValue[4], 0);
    msrRd = 1; cycle(); msrRd = 0;
    check("R8 change during read kept", msrValue[0], 1);
    msrRd = 1; cycle(); msrRd = 0;
    check("R8 cleared again", msrValue[0], 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule